// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block times the gap between chosen transitions of a fan's tachometer signal. The pin is first brought into the clock domain by a flop chain. A filter then passes a new level only after it has held for a selectable number of samples. From the filtered level, the block picks falling edges, rising edges or every edge. It counts ticks of a prescaled clock between two picked edges and presents the result as a measurement word.

Software reads the count only after the valid flag is up. It turns the count into a speed outside this block. The prescaler divides the clock by a power of four, so that slow fans still fit in the counter. A threshold compare can raise a sticky interrupt flag when a new measurement is too long. With the invert control set, it raises the flag when the measurement is too short instead.

Top module: `fan_tach_meter`

## Requirements
- R1: `raw_level` shows `tach_in` two clock edges after the input changes.
- R2: `deb_sel` encodes the filter depth in reverse order: a value v needs the synchronised level to differ from `deb_level` on 4-v consecutive edges. So 0 means 4 samples and 3 means 1 sample. `deb_level` therefore changes 6-v edges after a stable input change, and a pulse shorter than 4-v cycles never reaches it.
- R3: `edge_sel` 0 picks falling edges of `deb_level`, 1 picks rising edges, and 2 or 3 pick both.
- R4: `div_exp` e divides the count clock by 4^e, and the prescaler restarts on every picked edge. Two picked edges D cycles apart therefore give `meas_count` = floor((D-1)/4^e).
- R5: After `enable` rises, the first picked edge only starts timing and produces no measurement.
- R6: Each later picked edge latches the running count into `meas_count` and pulses `meas_update` high for one cycle. Both are due 7-v edges after the input change, where v is `deb_sel`. `meas_count` does not change at any other time.
- R7: The running count stops at all ones when no edge arrives, and that value is latched on the next picked edge.
- R8: `meas_full` rises with the first measurement. It drops one edge after `enable` is low. While `enable` is low, no measurement is made.
- R9: When a measurement is latched and `irq_en` is high, `irq_status` sets if the count is above `threshold`. With `limit_invert` high, it sets if the count is below `threshold` instead. An equal count never sets it.
- R10: `irq_status` stays set until an `irq_clear` pulse clears it on the next edge. A set on the same edge wins over the clear.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tach_in | input | 1 | Asynchronous tachometer pin |
| enable | input | 1 | Measurement enable |
| deb_sel | input | 2 | Filter depth code, reversed (0 = longest, 3 = shortest) |
| edge_sel | input | 2 | 0 falling, 1 rising, 2/3 both |
| div_exp | input | 4 | Prescaler exponent, divide by 4^e |
| threshold | input | CNT_W | Interrupt compare limit |
| irq_en | input | 1 | Allows the interrupt flag to set |
| limit_invert | input | 1 | Flag on short measurements instead of long ones |
| irq_clear | input | 1 | One-cycle pulse that clears the interrupt flag |
| raw_level | output | 1 | Synchronised, unfiltered input |
| deb_level | output | 1 | Filtered input |
| meas_count | output | CNT_W | Last latched measurement |
| meas_full | output | 1 | Measurement is valid |
| meas_update | output | 1 | One-cycle pulse on a new measurement |
| irq_status | output | 1 | Sticky interrupt flag |

## Verification
Each result has a fixed latency:
- `raw_level` follows the pin after 2 edges.
- `deb_level` follows after 6-v edges.
- `meas_count`, `meas_update` and `irq_status` follow after 7-v edges.
- `meas_full` drops and `irq_status` clears one edge after their controls.

The bench changes inputs just after a falling clock edge and reads outputs on falling edges. For the latency checks, it counts those falling edges from the stimulus until the output moves and compares the count to the figure above. The sweep over edge modes, filter depths and exponents waits well past the longest latency before it compares the recorded measurements with values computed by floor division.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int DEB_SEL_W = 2;
  localparam int EDGE_SEL_W = 2;
  localparam int EXP_W = 4;

  typedef enum logic [EDGE_SEL_W-1:0] {
    EDGE_FALL     = 2'd0,
    EDGE_RISE     = 2'd1,
    EDGE_BOTH     = 2'd2,
    EDGE_BOTH_ALT = 2'd3
  } edge_mode_e;
endpackage

// File: rtl/tach_input_filter.sv
module tach_input_filter
  import tach_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pin_i,
  input  logic [DEB_SEL_W-1:0] depth_code_i,
  output logic                 sync_o,
  output logic                 filt_o
);
  localparam logic [DEB_SEL_W-1:0] CODE_TOP = '1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DEB_SEL_W-1:0]   run_q;
  logic [DEB_SEL_W-1:0]   need;
  logic                   filt_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign sync_o = sync_q[SYNC_STAGES-1];
  // reversed encoding: largest code gives the shortest filter
  assign need = CODE_TOP - depth_code_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (sync_o != filt_q) begin
      if (run_q == need) begin
        filt_q <= sync_o;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/tach_edge_pick.sv
module tach_edge_pick
  import tach_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  level_i,
  input  logic [EDGE_SEL_W-1:0] mode_i,
  output logic                  hit_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  assign rise = level_i & ~prev_q;
  assign fall = ~level_i & prev_q;

  always_comb begin
    case (edge_mode_e'(mode_i))
      EDGE_FALL: hit_o = fall;
      EDGE_RISE: hit_o = rise;
      default:   hit_o = rise | fall;
    endcase
  end
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler
  import tach_pkg::*;
#(
  parameter int MAX_EXP = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int PRE_W = 2 * MAX_EXP;
  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(MAX_EXP);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;
  logic [EXP_W-1:0] exp_c;

  always_comb begin
    exp_c = (exp_i > EXP_CAP) ? EXP_CAP : exp_i;
    limit = (PRE_W'(1) << {exp_c, 1'b0}) - PRE_W'(1);
  end

  assign tick_o = (pre_q == limit);

  always_ff @(posedge clk) begin
    if (rst || restart_i || tick_o) pre_q <= '0;
    else                            pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tach_period_core.sv
module tach_period_core #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic             edge_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             irq_en_i,
  input  logic             invert_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             full_o,
  output logic             upd_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] run_q;
  logic             armed_q;
  logic             beyond;

  assign beyond = invert_i ? (run_q < limit_i) : (run_q > limit_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      armed_q <= 1'b0;
      meas_o  <= '0;
      full_o  <= 1'b0;
      upd_o   <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (clear_i) irq_o <= 1'b0;
      if (!enable_i) begin
        run_q   <= '0;
        armed_q <= 1'b0;
        full_o  <= 1'b0;
      end else if (edge_i) begin
        run_q <= '0;
        if (!armed_q) begin
          armed_q <= 1'b1;
        end else begin
          meas_o <= run_q;
          upd_o  <= 1'b1;
          full_o <= 1'b1;
          if (irq_en_i && beyond) irq_o <= 1'b1;
        end
      end else if (tick_i && run_q != CNT_TOP) begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import tach_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int MAX_EXP     = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tach_in,
  input  logic                  enable,
  input  logic [DEB_SEL_W-1:0]  deb_sel,
  input  logic [EDGE_SEL_W-1:0] edge_sel,
  input  logic [EXP_W-1:0]      div_exp,
  input  logic [CNT_W-1:0]      threshold,
  input  logic                  irq_en,
  input  logic                  limit_invert,
  input  logic                  irq_clear,
  output logic                  raw_level,
  output logic                  deb_level,
  output logic [CNT_W-1:0]      meas_count,
  output logic                  meas_full,
  output logic                  meas_update,
  output logic                  irq_status
);
  logic picked;
  logic tick;

  tach_input_filter #(.SYNC_STAGES(SYNC_STAGES)) filt_i (
    .clk(clk), .rst(rst), .pin_i(tach_in), .depth_code_i(deb_sel),
    .sync_o(raw_level), .filt_o(deb_level)
  );

  tach_edge_pick edge_i (
    .clk(clk), .rst(rst), .level_i(deb_level), .mode_i(edge_sel), .hit_o(picked)
  );

  tach_prescaler #(.MAX_EXP(MAX_EXP)) pre_i (
    .clk(clk), .rst(rst), .restart_i(picked | ~enable), .exp_i(div_exp), .tick_o(tick)
  );

  tach_period_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .enable_i(enable), .edge_i(picked), .tick_i(tick),
    .limit_i(threshold), .irq_en_i(irq_en), .invert_i(limit_invert), .clear_i(irq_clear),
    .meas_o(meas_count), .full_o(meas_full), .upd_o(meas_update), .irq_o(irq_status)
  );
endmodule

// File: rtl/tach_meter_checker.sv
module tach_meter_checker #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             irq_en,
  input logic             irq_clear,
  input logic             raw_level,
  input logic             deb_level,
  input logic [CNT_W-1:0] meas_count,
  input logic             meas_full,
  input logic             meas_update,
  input logic             irq_status
);
  AST_FULL_DROPS_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !meas_full); // R8
  AST_NO_UPDATE_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !meas_update); // R8
  AST_UPDATE_HAS_FULL: assert property (@(posedge clk) disable iff (rst)
    meas_update |-> meas_full); // R6
  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (rst)
    !meas_update |-> $stable(meas_count)); // R6
  AST_FILTER_FROM_SYNC: assert property (@(posedge clk) disable iff (rst)
    !$stable(deb_level) |-> deb_level == $past(raw_level)); // R2
  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (rst)
    irq_clear |=> (!irq_status || meas_update)); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_status) |-> (meas_update && $past(irq_en))); // R9
endmodule

bind fan_tach_meter tach_meter_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .enable(enable), .irq_en(irq_en), .irq_clear(irq_clear),
  .raw_level(raw_level), .deb_level(deb_level), .meas_count(meas_count),
  .meas_full(meas_full), .meas_update(meas_update), .irq_status(irq_status)
);

// File: tb/fan_tach_meter_tb_top.sv
`timescale 1ns/1ps
module fan_tach_meter_tb_top;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tach_in, enable, irq_en, limit_invert, irq_clear;
  logic [1:0] deb_sel, edge_sel;
  logic [3:0] div_exp;
  logic [CNT_W-1:0] threshold;
  logic raw_level, deb_level, meas_full, meas_update, irq_status;
  logic [CNT_W-1:0] meas_count;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  int n_upd = 0;
  int upd_val [0:1023];

  always #2 clk = ~clk;

  fan_tach_meter #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .tach_in(tach_in), .enable(enable), .deb_sel(deb_sel),
    .edge_sel(edge_sel), .div_exp(div_exp), .threshold(threshold), .irq_en(irq_en),
    .limit_invert(limit_invert), .irq_clear(irq_clear), .raw_level(raw_level),
    .deb_level(deb_level), .meas_count(meas_count), .meas_full(meas_full),
    .meas_update(meas_update), .irq_status(irq_status)
  );

  always @(negedge clk) begin
    if (!rst && meas_update) begin
      if (n_upd < 1024) upd_val[n_upd] = int'(meas_count);
      n_upd++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_train(input int hi, input int lo, input int n);
    for (int i = 0; i < n; i++) begin
      tach_in = 1'b1; step(hi);
      tach_in = 1'b0; step(lo);
    end
  endtask

  task automatic flip_after(input int k);
    step(k);
    tach_in = ~tach_in;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int k, cnt_up, v, base, got, expn, d, expv, tgt;
    bit seen;
    tach_in = 0; enable = 0; deb_sel = 2'd3; edge_sel = 2'd0; div_exp = 4'd0;
    threshold = '0; irq_en = 0; limit_invert = 0; irq_clear = 0;
    step(5); rst = 1'b0; step(1);

    // R11 reset state
    check(raw_level == 0 && deb_level == 0 && meas_count == 0 && !meas_full &&
          !meas_update && !irq_status, "R11",
          int'(meas_count) + int'(raw_level) + int'(deb_level) + int'(meas_full) +
          int'(meas_update) + int'(irq_status), 0);

    // R1 synchroniser latency
    tach_in = 1'b1; step(1);
    check(raw_level == 1'b0, "R1 after one edge", int'(raw_level), 0);
    step(1);
    check(raw_level == 1'b1, "R1 after two edges", int'(raw_level), 1);
    tach_in = 1'b0; step(12);

    // R2 filter latency for every depth code
    for (int s = 0; s < 4; s++) begin
      deb_sel = 2'(s); step(2);
      tach_in = ~tach_in; k = 0;
      for (int i = 1; i <= 12; i++) begin
        step(1);
        if (deb_level == tach_in && k == 0) k = i;
      end
      check(k == 6 - s, "R2 latency", k, 6 - s);
    end

    // R2 short pulses rejected, long enough pulses pass
    for (int s = 0; s < 4; s++) begin
      deb_sel = 2'(s); step(2);
      tgt = int'(deb_level); seen = 0;
      if (s < 3) begin
        tach_in = ~tach_in;
        for (int i = 0; i < 3 - s; i++) begin step(1); if (int'(deb_level) != tgt) seen = 1; end
        tach_in = ~tach_in;
        for (int i = 0; i < 12; i++) begin step(1); if (int'(deb_level) != tgt) seen = 1; end
        check(seen == 0, "R2 short pulse ignored", int'(seen), 0);
      end
      seen = 0;
      tach_in = ~tach_in;
      for (int i = 0; i < 4 - s; i++) begin step(1); if (int'(deb_level) != tgt) seen = 1; end
      tach_in = ~tach_in;
      for (int i = 0; i < 12; i++) begin step(1); if (int'(deb_level) != tgt) seen = 1; end
      check(seen == 1, "R2 minimum pulse passes", int'(seen), 1);
      check(int'(deb_level) == tgt, "R2 level restored", int'(deb_level), tgt);
    end

    // R6 update latency, pulse width and value
    enable = 1; edge_sel = 2'd2; div_exp = 4'd0;
    for (int s = 0; s < 4; s++) begin
      deb_sel = 2'(s); step(3);
      tach_in = ~tach_in; step(25);
      tach_in = ~tach_in;
      k = 0; cnt_up = 0; v = -1;
      for (int i = 1; i <= 14; i++) begin
        step(1);
        if (meas_update) begin
          cnt_up++;
          if (k == 0) begin k = i; v = int'(meas_count); end
        end
      end
      check(k == 7 - s, "R6 update latency", k, 7 - s);
      check(cnt_up == 1, "R6 single-cycle pulse", cnt_up, 1);
      check(v == 24, "R6 latched count", v, 24);
    end
    enable = 0; step(2);

    // R3 R4 R5 R8 sweep over edge modes, depths and exponents
    for (int es = 0; es < 3; es++)
      for (int ds = 0; ds < 4; ds++)
        for (int ex = 0; ex < 3; ex++) begin
          enable = 0; step(2);
          edge_sel = 2'(es); deb_sel = 2'(ds); div_exp = 4'(ex);
          enable = 1; step(8);
          base = n_upd;
          pulse_train(23, 31, 3);
          step(20);
          d = 1 << (2 * ex);
          expn = (es < 2) ? 2 : 5;
          got = n_upd - base;
          check(got == expn, "R3/R5 measurement count", got, expn);
          for (int j = 0; j < expn && j < got; j++) begin
            if (es < 2) expv = 53 / d;
            else expv = (j % 2 == 0) ? 22 / d : 30 / d;
            check(upd_val[base + j] == expv, "R4 measured value", upd_val[base + j], expv);
          end
          check(meas_full == 1'b1, "R8 full set", int'(meas_full), 1);
        end

    // R8 flag drop and no measurement while disabled
    enable = 0; step(1);
    check(meas_full == 1'b0, "R8 full cleared", int'(meas_full), 0);
    base = n_upd;
    pulse_train(10, 10, 3); step(10);
    check(n_upd == base, "R8 no update while disabled", n_upd - base, 0);

    // R7 saturation
    edge_sel = 2'd0; deb_sel = 2'd3; div_exp = 4'd0;
    enable = 1; step(5);
    base = n_upd;
    pulse_train(10, 1490, 2); step(20);
    check(n_upd - base == 1, "R7 update count", n_upd - base, 1);
    check(int'(meas_count) == 1023, "R7 saturated value", int'(meas_count), 1023);

    // R9 R10 interrupt
    enable = 0; step(2);
    edge_sel = 2'd2; deb_sel = 2'd3; threshold = CNT_W'(40);
    irq_en = 1; limit_invert = 0; enable = 1; step(5);
    flip_after(0);
    flip_after(30); step(8);
    check(irq_status == 0, "R9 below limit", int'(irq_status), 0);
    flip_after(33); step(8);
    check(irq_status == 0, "R9 equal to limit", int'(irq_status), 0);
    flip_after(52); step(8);
    check(int'(meas_count) == 59, "R9 value", int'(meas_count), 59);
    check(irq_status == 1, "R9 above limit", int'(irq_status), 1);
    irq_clear = 1; step(1); irq_clear = 0;
    check(irq_status == 0, "R10 cleared", int'(irq_status), 0);
    step(1);
    limit_invert = 1;
    flip_after(31); step(8);
    check(irq_status == 0, "R9 inverted equal", int'(irq_status), 0);
    flip_after(12); step(8);
    check(irq_status == 1, "R9 inverted below", int'(irq_status), 1);
    irq_clear = 1; step(1); irq_clear = 0; step(1);
    irq_en = 0;
    flip_after(10); step(8);
    check(irq_status == 0, "R9 gated by irq_en", int'(irq_status), 0);
    irq_en = 1;
    flip_after(12); step(3);
    irq_clear = 1; step(1); irq_clear = 0;
    check(irq_status == 1, "R10 set wins over clear", int'(irq_status), 1);
    check(meas_update == 1, "R6 update on same edge", int'(meas_update), 1);
    step(20);
    check(irq_status == 1, "R10 flag held", int'(irq_status), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule